// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a small microcontroller core between normal execution, a light sleep in which instruction fetch halts but peripherals keep their clock, and a deep sleep in which the oscillator itself is shut off. It turns software sleep requests, interrupt activity and the raw reset pin into registered clock-gating enables for the CPU and the peripherals. It also drives a run request to the oscillator, a run enable for the peripheral counter and a qualified internal reset.

Software picks the sleep depth with two request strobes; deep sleep wins when both arrive together. Light sleep ends on any enabled interrupt or on the reset pin. Deep sleep ends only on a qualified reset or on an enabled external interrupt pin that is configured as level-sensitive. Pulling that pin low restarts the oscillator, and the core resumes once the pin is released and the oscillator reports that it is stable. When the reset pin cuts a light sleep short, the core briefly runs again before the internal reset takes hold. A write-block flag covers this window so that the RAM cannot be disturbed.

Top module: `lpm_ctrl`

## Requirements
- R1: `int_rst` goes high after the HOLD-th consecutive rising edge at which both `rst_pin` and `osc_stable` are 1, where HOLD = MC_CYCLES*RST_MC. Edges with `osc_stable` = 0 do not count. `int_rst` drops after the first edge with `rst_pin` = 0. While `int_rst` is high, and on the edge after it falls, the outputs hold the run values: `cpu_clk_en`, `per_clk_en`, `osc_run_en` and `ptmr_run_en` at 1, and `wake_resume` and `ram_wr_block` at 0.
- R2: In run, a `req_idle` sampled at an edge gives `cpu_clk_en` = 0 from that edge on, while `per_clk_en` and `osc_run_en` stay 1.
- R3: While idling, `ptmr_run_en` follows the `idle_timer_run` option sampled at the previous edge: 1 keeps the counter running and 0 pauses it. In run it is 1.
- R4: While idling, `irq_pend` = 1 at an edge returns the core to run at that edge (`cpu_clk_en` = 1), with `wake_resume` high for exactly that one cycle.
- R5: In run, `req_pdown` at an edge clears `cpu_clk_en`, `per_clk_en`, `osc_run_en` and `ptmr_run_en`. It takes precedence over a `req_idle` at the same edge.
- R6: In power-down the outputs do not change for `irq_pend`, for a pin whose enable bit is 0, or for a pin whose `ext_int_edge` bit is 1 (edge-configured).
- R7: In power-down, a pin i with `ext_int_en[i]` = 1, `ext_int_edge[i]` = 0 and `ext_int_n[i]` = 0 raises `osc_run_en` at that edge while `cpu_clk_en` stays 0. The wake completes only once every such enabled level pin reads 1.
- R8: After the level pins are released, `cpu_clk_en` returns at the first edge with `osc_stable` = 1, together with a one-cycle `wake_resume`. Until then only `osc_run_en` is high.
- R9: In power-down, `rst_pin` = 1 at an edge sets `osc_run_en` at that edge, so that reset qualification can proceed. The qualified reset then restores the run values.
- R10: While idling, `rst_pin` = 1 at an edge sets both `cpu_clk_en` and `ram_wr_block` at that edge. `ram_wr_block` stays high until the edge after `int_rst` rises, and it clears with `cpu_clk_en` still 1 if the pin falls before qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset pin, active high |
| osc_stable | input | 1 | Oscillator has settled |
| req_idle | input | 1 | Software request for idle |
| req_pdown | input | 1 | Software request for power-down |
| irq_pend | input | 1 | Any enabled interrupt pending |
| ext_int_n | input | NUM_EXT | External interrupt pins, active low |
| ext_int_en | input | NUM_EXT | Per-pin interrupt enable |
| ext_int_edge | input | NUM_EXT | Per-pin mode: 1 edge, 0 level |
| idle_timer_run | input | 1 | Keep peripheral counter running in idle |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run_en | output | 1 | Oscillator run request |
| ptmr_run_en | output | 1 | Peripheral counter run enable |
| int_rst | output | 1 | Qualified internal reset |
| wake_resume | output | 1 | One-cycle pulse on interrupt wake |
| ram_wr_block | output | 1 | Internal RAM writes blocked |

## Verification
The bench builds the block with MC_CYCLES = 4, RST_MC = 2 and NUM_EXT = 2, so the reset hold window is eight clocks. Every hold length short of that window can be tried, along with the exact boundary. With two pins, all 64 combinations of enable, mode and pin level can be applied in power-down, and the expected wake is computed from the pin equation. Successive wakes alternate between a stable and an unstable oscillator, which covers both the direct path back to run and the settling path.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    PM_RUN    = 3'd0,
    PM_IDLE   = 3'd1,
    PM_DOWN   = 3'd2,
    PM_WAKE   = 3'd3,
    PM_SETTLE = 3'd4,
    PM_RSTWIN = 3'd5
  } pm_state_e;

  typedef struct packed {
    logic cpu_en;
    logic per_en;
    logic osc_en;
    logic tmr_en;
    logic resume;
    logic ram_blk;
  } pm_ctl_t;

  function automatic pm_ctl_t mk_ctl(input logic cpu, input logic per, input logic osc,
                                     input logic tmr, input logic res, input logic blk);
    pm_ctl_t c;
    c.cpu_en  = cpu;
    c.per_en  = per;
    c.osc_en  = osc;
    c.tmr_en  = tmr;
    c.resume  = res;
    c.ram_blk = blk;
    return c;
  endfunction

endpackage

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
  parameter int MC_CYCLES = 12,
  parameter int RST_MC    = 2
) (
  input  logic clk,
  input  logic rst_pin,
  input  logic osc_stable,
  output logic int_rst
);
  localparam int HOLD = MC_CYCLES * RST_MC;
  localparam int CW   = $clog2(HOLD + 1);
  localparam logic [CW-1:0] SAT  = CW'(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] hold_cnt;
  logic          rst_q;

  // counts only clocks on which the oscillator is known good
  always_ff @(posedge clk) begin
    if (!rst_pin) begin
      hold_cnt <= '0;
      rst_q    <= 1'b0;
    end else begin
      if (osc_stable && hold_cnt != SAT) hold_cnt <= hold_cnt + 1'b1;
      rst_q <= rst_q | (osc_stable && hold_cnt == LAST);
    end
  end

  assign int_rst = rst_q;

endmodule

// File: rtl/lpm_wake_lvl.sv
module lpm_wake_lvl #(
  parameter int NUM_EXT = 2
) (
  input  logic [NUM_EXT-1:0] ext_int_n,
  input  logic [NUM_EXT-1:0] ext_int_en,
  input  logic [NUM_EXT-1:0] ext_int_edge,
  output logic               lvl_wake
);
  logic [NUM_EXT-1:0] hit;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
    // only an enabled, level-configured pin held low may wake deep sleep
    assign hit[i] = ext_int_en[i] & ~ext_int_edge[i] & ~ext_int_n[i];
  end

  assign lvl_wake = |hit;

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
(
  input  logic    clk,
  input  logic    int_rst,
  input  logic    rst_pin,
  input  logic    osc_stable,
  input  logic    req_idle,
  input  logic    req_pdown,
  input  logic    irq_pend,
  input  logic    lvl_wake,
  input  logic    idle_timer_run,
  output pm_ctl_t ctl
);
  pm_state_e st_q, st_d;
  logic      resume_d;
  pm_ctl_t   ctl_d;

  always_comb begin
    st_d     = st_q;
    resume_d = 1'b0;
    case (st_q)
      PM_RUN: begin
        if (req_pdown)     st_d = PM_DOWN;
        else if (req_idle) st_d = PM_IDLE;
      end
      PM_IDLE: begin
        if (rst_pin) st_d = PM_RSTWIN;
        else if (irq_pend) begin
          st_d     = PM_RUN;
          resume_d = 1'b1;
        end
      end
      PM_DOWN: begin
        if (lvl_wake) st_d = PM_WAKE;
      end
      PM_WAKE: begin
        if (!lvl_wake) begin
          if (osc_stable) begin
            st_d     = PM_RUN;
            resume_d = 1'b1;
          end else begin
            st_d = PM_SETTLE;
          end
        end
      end
      PM_SETTLE: begin
        if (osc_stable) begin
          st_d     = PM_RUN;
          resume_d = 1'b1;
        end
      end
      PM_RSTWIN: begin
        if (!rst_pin) st_d = PM_RUN;
      end
      default: st_d = PM_RUN;
    endcase
  end

  always_comb begin
    case (st_d)
      PM_IDLE:   ctl_d = mk_ctl(1'b0, 1'b1, 1'b1, idle_timer_run, 1'b0, 1'b0);
      PM_DOWN:   ctl_d = mk_ctl(1'b0, 1'b0, rst_pin, 1'b0, 1'b0, 1'b0);
      PM_WAKE,
      PM_SETTLE: ctl_d = mk_ctl(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      PM_RSTWIN: ctl_d = mk_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      default:   ctl_d = mk_ctl(1'b1, 1'b1, 1'b1, 1'b1, resume_d, 1'b0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (int_rst) begin
      st_q <= PM_RUN;
      ctl  <= mk_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    end else begin
      st_q <= st_d;
      ctl  <= ctl_d;
    end
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int MC_CYCLES = 12,
  parameter int RST_MC    = 2,
  parameter int NUM_EXT   = 2
) (
  input  logic               clk,
  input  logic               rst_pin,
  input  logic               osc_stable,
  input  logic               req_idle,
  input  logic               req_pdown,
  input  logic               irq_pend,
  input  logic [NUM_EXT-1:0] ext_int_n,
  input  logic [NUM_EXT-1:0] ext_int_en,
  input  logic [NUM_EXT-1:0] ext_int_edge,
  input  logic               idle_timer_run,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               osc_run_en,
  output logic               ptmr_run_en,
  output logic               int_rst,
  output logic               wake_resume,
  output logic               ram_wr_block
);
  logic    lvl_wake;
  pm_ctl_t ctl;

  lpm_rst_qual #(.MC_CYCLES(MC_CYCLES), .RST_MC(RST_MC)) u_rst_qual (
    .clk(clk), .rst_pin(rst_pin), .osc_stable(osc_stable), .int_rst(int_rst)
  );

  lpm_wake_lvl #(.NUM_EXT(NUM_EXT)) u_wake_lvl (
    .ext_int_n(ext_int_n), .ext_int_en(ext_int_en), .ext_int_edge(ext_int_edge),
    .lvl_wake(lvl_wake)
  );

  lpm_seq u_seq (
    .clk(clk), .int_rst(int_rst), .rst_pin(rst_pin), .osc_stable(osc_stable),
    .req_idle(req_idle), .req_pdown(req_pdown), .irq_pend(irq_pend),
    .lvl_wake(lvl_wake), .idle_timer_run(idle_timer_run), .ctl(ctl)
  );

  assign cpu_clk_en   = ctl.cpu_en;
  assign per_clk_en   = ctl.per_en;
  assign osc_run_en   = ctl.osc_en;
  assign ptmr_run_en  = ctl.tmr_en;
  assign wake_resume  = ctl.resume;
  assign ram_wr_block = ctl.ram_blk;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int NUM_EXT = 2
) (
  input logic               clk,
  input logic               rst_pin,
  input logic               osc_stable,
  input logic               req_pdown,
  input logic               irq_pend,
  input logic [NUM_EXT-1:0] ext_int_n,
  input logic [NUM_EXT-1:0] ext_int_en,
  input logic [NUM_EXT-1:0] ext_int_edge,
  input logic               idle_timer_run,
  input logic               cpu_clk_en,
  input logic               per_clk_en,
  input logic               osc_run_en,
  input logic               ptmr_run_en,
  input logic               int_rst,
  input logic               wake_resume,
  input logic               ram_wr_block
);
  logic started = 1'b0;
  logic armed   = 1'b0;
  always_ff @(posedge clk) begin
    started <= 1'b1;
    if (int_rst) armed <= 1'b1;
  end

  logic lvl_any;
  assign lvl_any = |(ext_int_en & ~ext_int_edge & ~ext_int_n);

  // R1
  rst_qual_chk: assert property (@(posedge clk) disable iff (!started)
    $rose(int_rst) |-> $past(rst_pin) && $past(osc_stable));

  // R3
  idle_tmr_chk: assert property (@(posedge clk) disable iff (!armed || int_rst)
    (!cpu_clk_en && per_clk_en) |-> ptmr_run_en == $past(idle_timer_run));

  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (!armed || int_rst)
    (!cpu_clk_en && per_clk_en && irq_pend && !rst_pin) |=> cpu_clk_en && wake_resume);

  // R4
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!armed || int_rst)
    wake_resume |=> !wake_resume);

  // R5
  pd_priority_chk: assert property (@(posedge clk) disable iff (!armed || int_rst)
    (cpu_clk_en && per_clk_en && !ram_wr_block && req_pdown) |=> !cpu_clk_en && !per_clk_en);

  // R6
  pd_ignore_chk: assert property (@(posedge clk) disable iff (!armed || int_rst)
    (!cpu_clk_en && !per_clk_en && !osc_run_en && !rst_pin && !lvl_any) |=> !cpu_clk_en && !per_clk_en);

  // R8
  pd_osc_gate_chk: assert property (@(posedge clk) disable iff (!armed || int_rst)
    (cpu_clk_en && !$past(cpu_clk_en) && !$past(per_clk_en) && !$past(int_rst)) |-> $past(osc_stable));

  // R10
  ram_block_chk: assert property (@(posedge clk) disable iff (!armed)
    ram_wr_block |-> cpu_clk_en && per_clk_en);

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_EXT(NUM_EXT)) u_lpm_ctrl_chk (
  .clk(clk), .rst_pin(rst_pin), .osc_stable(osc_stable), .req_pdown(req_pdown),
  .irq_pend(irq_pend), .ext_int_n(ext_int_n), .ext_int_en(ext_int_en),
  .ext_int_edge(ext_int_edge), .idle_timer_run(idle_timer_run),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run_en(osc_run_en),
  .ptmr_run_en(ptmr_run_en), .int_rst(int_rst), .wake_resume(wake_resume),
  .ram_wr_block(ram_wr_block)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
  localparam int MC   = 4;
  localparam int RMC  = 2;
  localparam int NE   = 2;
  localparam int HOLD = MC * RMC;

  logic clk = 1'b0;
  logic rst_pin = 1'b0, osc_stable = 1'b1, req_idle = 1'b0, req_pdown = 1'b0, irq_pend = 1'b0;
  logic [NE-1:0] ext_int_n = '1, ext_int_en = '0, ext_int_edge = '0;
  logic idle_timer_run = 1'b0;
  logic cpu_clk_en, per_clk_en, osc_run_en, ptmr_run_en, int_rst, wake_resume, ram_wr_block;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpm_ctrl #(.MC_CYCLES(MC), .RST_MC(RMC), .NUM_EXT(NE)) u_lpm_ctrl (
    .clk(clk), .rst_pin(rst_pin), .osc_stable(osc_stable), .req_idle(req_idle),
    .req_pdown(req_pdown), .irq_pend(irq_pend), .ext_int_n(ext_int_n),
    .ext_int_en(ext_int_en), .ext_int_edge(ext_int_edge), .idle_timer_run(idle_timer_run),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run_en(osc_run_en),
    .ptmr_run_en(ptmr_run_en), .int_rst(int_rst), .wake_resume(wake_resume),
    .ram_wr_block(ram_wr_block)
  );

  // {cpu, per, osc, tmr, resume, ram_blk}
  wire [5:0] obs = {cpu_clk_en, per_clk_en, osc_run_en, ptmr_run_en, wake_resume, ram_wr_block};
  localparam logic [5:0] V_RUN  = 6'b111100;
  localparam logic [5:0] V_RES  = 6'b111110;
  localparam logic [5:0] V_DOWN = 6'b000000;
  localparam logic [5:0] V_WAKE = 6'b001000;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic full_reset();
    rst_pin = 1'b1;
    osc_stable = 1'b1;
    repeat (HOLD) tick();
    rst_pin = 1'b0;
    tick();
    tick();
  endtask

  task automatic enter_down();
    req_pdown = 1'b1;
    tick();
    req_pdown = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int wakes = 0;
    @(negedge clk);
    tick();
    tick();
    // R1: exact hold boundary
    rst_pin = 1'b1;
    repeat (HOLD - 1) tick();
    chk("R1 no reset before hold", {5'b0, int_rst}, 6'd0);
    tick();
    chk("R1 reset at hold", {5'b0, int_rst}, 6'd1);
    chk("R1 reset outputs", obs, V_RUN);
    rst_pin = 1'b0;
    tick();
    chk("R1 reset release", {5'b0, int_rst}, 6'd0);
    tick();
    chk("R1 run after reset", obs, V_RUN);

    // R1: every short hold length is rejected
    for (int n = 1; n < HOLD; n++) begin
      rst_pin = 1'b1;
      repeat (n) tick();
      rst_pin = 1'b0;
      tick();
      chk($sformatf("R1 short hold %0d", n), {int_rst, obs[5:1]}, {1'b0, V_RUN[5:1]});
    end
    // R1: clocks without a stable oscillator do not count
    osc_stable = 1'b0;
    rst_pin = 1'b1;
    repeat (2 * HOLD) tick();
    chk("R1 unstable oscillator", {5'b0, int_rst}, 6'd0);
    rst_pin = 1'b0;
    osc_stable = 1'b1;
    tick();

    // R2 R3 R4: idle with both option values
    for (int opt = 0; opt < 2; opt++) begin
      idle_timer_run = opt[0];
      req_idle = 1'b1;
      tick();
      req_idle = 1'b0;
      chk("R2 idle entry", obs, {3'b011, opt[0], 2'b00});
      repeat (3) tick();
      chk("R3 idle timer option", obs, {3'b011, opt[0], 2'b00});
      irq_pend = 1'b1;
      tick();
      irq_pend = 1'b0;
      chk("R4 idle wake", obs, V_RES);
      tick();
      chk("R4 resume single cycle", obs, V_RUN);
    end

    // R5: power-down wins over a simultaneous idle request
    req_idle = 1'b1;
    req_pdown = 1'b1;
    tick();
    req_idle = 1'b0;
    req_pdown = 1'b0;
    chk("R5 power-down priority", obs, V_DOWN);

    // R6 R7 R8: sweep of every pin configuration in power-down
    for (int cfg = 0; cfg < 64; cfg++) begin
      logic [NE-1:0] en, edg, pn;
      logic wk;
      en  = cfg[1:0];
      edg = cfg[3:2];
      pn  = cfg[5:4];
      wk  = |(en & ~edg & ~pn);
      ext_int_en = en;
      ext_int_edge = edg;
      ext_int_n = pn;
      irq_pend = 1'b1;
      tick();
      irq_pend = 1'b0;
      if (!wk) begin
        chk($sformatf("R6 ignored cfg %0d", cfg), obs, V_DOWN);
        ext_int_n = '1;
        tick();
      end else begin
        chk($sformatf("R7 level wake cfg %0d", cfg), obs, V_WAKE);
        tick();
        chk($sformatf("R7 held low cfg %0d", cfg), obs, V_WAKE);
        wakes++;
        if (wakes % 2 == 0) begin
          osc_stable = 1'b0;
          ext_int_n = '1;
          tick();
          tick();
          chk($sformatf("R8 wait stable cfg %0d", cfg), obs, V_WAKE);
          osc_stable = 1'b1;
          tick();
        end else begin
          ext_int_n = '1;
          tick();
        end
        chk($sformatf("R8 resume cfg %0d", cfg), obs, V_RES);
        tick();
        chk($sformatf("R8 run cfg %0d", cfg), obs, V_RUN);
        ext_int_en = '0;
        ext_int_edge = '0;
        enter_down();
      end
      ext_int_en = '0;
      ext_int_edge = '0;
    end

    // R9: reset from power-down
    chk("R9 still down", obs, V_DOWN);
    rst_pin = 1'b1;
    tick();
    chk("R9 oscillator restarted", obs, V_WAKE);
    repeat (HOLD - 1) tick();
    chk("R9 reset qualified", {5'b0, int_rst}, 6'd1);
    rst_pin = 1'b0;
    tick();
    tick();
    chk("R9 run after reset", obs, V_RUN);

    // R10: reset during idle with RAM write block
    idle_timer_run = 1'b0;
    req_idle = 1'b1;
    tick();
    req_idle = 1'b0;
    rst_pin = 1'b1;
    tick();
    chk("R10 block window", obs, 6'b111101);
    repeat (HOLD - 1) tick();
    chk("R10 block during reset", {int_rst, obs[0]}, 2'b11);
    tick();
    chk("R10 block cleared", obs, V_RUN);
    rst_pin = 1'b0;
    tick();
    tick();
    // R10: short pulse during idle releases back to run
    req_idle = 1'b1;
    tick();
    req_idle = 1'b0;
    rst_pin = 1'b1;
    tick();
    tick();
    rst_pin = 1'b0;
    tick();
    chk("R10 glitch release", {int_rst, obs[5:0]}, {1'b0, V_RUN});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule